// File: doc/BRIEF.md
# Four-Lane Serial Audio Transmitter

This block turns parallel audio samples into serial audio on four data lines. Eight channels arrive together as four stereo pairs, one pair for each line, through a valid/ready handshake. The block drives all four lines from a single bit clock and a single word clock. It derives both clocks from its own master clock, and it runs as the clock master, so a downstream codec or a serializer sink can receive the stream directly.

Every frame holds 64 bit clocks: a left half-frame of 32 slots and then a right half-frame of 32 slots. Three framing modes are available. Standard I2S places the MSB one bit clock after the word clock edge. Left-justified places the MSB on the edge itself. Right-justified ends the word on the last slot of the half-frame. The word length can be set from 1 to 24 bits. The mode and the word length are sampled once, at the start of each frame, so a change made partway through a frame cannot tear that frame. The input has one frame of buffering. If that buffer is empty when a frame starts, the block sends the previous samples again and raises an underrun flag for that frame.

Top module: `i2s_quad_tx`

## Requirements
- R1: `sclk` is low after reset. Each high phase and each low phase of `sclk` lasts `cfg_div`+1 cycles of `clk_m`, which gives a 50% duty cycle.
- R2: `sd` and `lrclk` change only in a `clk_m` cycle in which `sclk` goes from high to low.
- R3: A frame is 64 `sclk` periods. `lrclk` is low for the 32 left-channel slots and high for the 32 right-channel slots. Bits are sent MSB first.
- R4: When `cfg_mode` is 0 or 3 (standard I2S), the MSB occupies slot 1 of the half-frame (slot 0 is the first rising `sclk` after the `lrclk` edge). The word then fills slots 1..W, and every other slot is 0.
- R5: When `cfg_mode` is 1 (left-justified), the word fills slots 0..W-1 with the MSB in slot 0, and every other slot is 0.
- R6: When `cfg_mode` is 2 (right-justified), the LSB falls in slot 31. The word fills slots 32-W..31, and every other slot is 0.
- R7: The effective word length W is `cfg_wl` clamped to the range 1..24, so 0 gives 1 and any value above 24 gives 24. Only the low W bits of each 24-bit sample field are sent. Bits above W have no effect on `sd`.
- R8: Lane l carries the sample in `in_samples[(2l)*24 +: 24]` in its left half-frame and the sample in `in_samples[(2l+1)*24 +: 24]` in its right half-frame.
- R9: `in_ready` is high while the one-frame buffer is empty. A transfer occurs on a rising `clk_m` edge when `in_valid` and `in_ready` are both high. `in_ready` then stays low until the next frame start takes the buffered samples.
- R10: If the buffer is empty at a frame start, that frame repeats the previous samples and `underrun` is high for the whole frame. A frame that starts with fresh samples has `underrun` low.
- R11: `cfg_mode` and `cfg_wl` are sampled at each frame start. A change during a frame takes effect only from the next frame.
- R12: During reset, `sclk`=0, `lrclk`=1, `sd`=0, `underrun`=0 and `in_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_m | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_div | input | 8 | Length of an `sclk` phase in `clk_m` cycles, minus one |
| cfg_mode | input | 2 | Framing mode: 0/3 standard, 1 left-justified, 2 right-justified |
| cfg_wl | input | 5 | Requested word length in bits |
| in_valid | input | 1 | A sample set is present on `in_samples` |
| in_ready | output | 1 | The buffer can take a sample set |
| in_samples | input | 192 | Eight 24-bit samples, lane-major, left channel first |
| sclk | output | 1 | Bit clock |
| lrclk | output | 1 | Word clock (low selects the left channel) |
| sd | output | 4 | Serial data, one bit per lane |
| underrun | output | 1 | The current frame repeats the previous samples |

## Verification
The bench decodes the serial stream the way a receiver would. It samples at each rising `sclk` and re-aligns on every `lrclk` edge. It compares each 32-slot half-frame with a slot image built arithmetically from the sample, the mode and the clamped word length. The corner cases it targets are these:
- Word lengths 1 and 24, and out-of-range lengths. A design off by one in the I2S delay, or one that ignores the clamp, would shift the word or leak stray upper bits into the zero slots.
- A mode change in the middle of a frame. A design that does not latch the configuration at the frame start would tear that frame.
- A gap in the input. A design that handles the gap badly would send zeros or stale lanes, or would fail to raise or drop `underrun` on the frame boundary.
- Dividers above zero. A design that advances the data on the wrong phase, or counts the phase length wrongly, would break the edge and duty checks.

// File: rtl/i2s_ser_pkg.sv
package i2s_ser_pkg;

  typedef enum logic [1:0] {
    FMT_I2S   = 2'd0,
    FMT_LEFT  = 2'd1,
    FMT_RIGHT = 2'd2
  } fmt_e;

  localparam int unsigned SLOT_BITS = 32;

  // Map the raw mode code to a framing mode; code 3 falls back to standard.
  function automatic fmt_e decode_fmt(input logic [1:0] code);
    case (code)
      2'd1:    return FMT_LEFT;
      2'd2:    return FMT_RIGHT;
      default: return FMT_I2S;
    endcase
  endfunction

  // Clamp a requested word length into 1..maxw.
  function automatic logic [4:0] clamp_wl(input logic [4:0] raw, input int unsigned maxw);
    if (raw == 5'd0) return 5'd1;
    if (32'(raw) > maxw) return 5'(maxw);
    return raw;
  endfunction

  // Value of slot k of a half-frame for a right-aligned word of w bits.
  function automatic logic slot_bit(input fmt_e f, input logic [4:0] w,
                                    input logic [4:0] k, input logic [31:0] word);
    logic [5:0] kk;
    logic [5:0] ww;
    logic [4:0] idx;
    logic       hit;
    kk  = {1'b0, k};
    ww  = {1'b0, w};
    hit = 1'b0;
    idx = 5'd0;
    case (f)
      FMT_LEFT: begin
        hit = (kk < ww);
        idx = 5'(ww - 6'd1 - kk);
      end
      FMT_RIGHT: begin
        hit = (kk >= 6'(SLOT_BITS) - ww);
        idx = 5'(6'd31 - kk);
      end
      default: begin
        hit = (kk >= 6'd1) && (kk <= ww);
        idx = 5'(ww - kk);
      end
    endcase
    return hit ? word[idx] : 1'b0;
  endfunction

endpackage

// File: rtl/i2s_clkdiv.sv
module i2s_clkdiv #(
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DIVW-1:0] half_m1,
  output logic            sclk,
  output logic            fall_tick
);

  logic [DIVW-1:0] cnt;
  logic            wrap;

  assign wrap      = (cnt >= half_m1);
  assign fall_tick = wrap && sclk;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (wrap) begin
      cnt  <= '0;
      sclk <= ~sclk;
    end else begin
      cnt  <= cnt + 1'b1;
    end
  end

  // R2: the bit clock only falls where the tick announced it
  a_r2_fall_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |-> $past(fall_tick));

  // R1: a tick always produces a falling bit clock
  a_r1_tick_falls: assert property (@(posedge clk) disable iff (!rst_n)
    fall_tick |=> !sclk);

endmodule

// File: rtl/i2s_framer.sv
module i2s_framer (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fall_tick,
  output logic [5:0] pos_next,
  output logic       frame_start,
  output logic       lrclk
);

  logic [5:0] pos;

  assign pos_next    = pos + 6'd1;
  assign frame_start = fall_tick && (pos_next == 6'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos   <= 6'd63;
      lrclk <= 1'b1;
    end else if (fall_tick) begin
      pos   <= pos_next;
      lrclk <= pos_next[5];
    end
  end

  // R2: word clock holds between falling bit-clock edges
  a_r2_lr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_tick |=> $stable(lrclk));

  // R3: word clock only toggles at a half-frame boundary
  a_r3_lr_mid_half: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_tick && pos_next[4:0] != 5'd0) |=> $stable(lrclk));

endmodule

// File: rtl/i2s_lane.sv
module i2s_lane
  import i2s_ser_pkg::*;
#(
  parameter int SW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fall_tick,
  input  fmt_e          fmt,
  input  logic [4:0]    wl,
  input  logic [5:0]    pos_next,
  input  logic [SW-1:0] word_l,
  input  logic [SW-1:0] word_r,
  output logic          sd
);

  localparam int PADW = 32 - SW;

  logic [31:0] word_ext;
  logic [4:0]  k_next;

  assign k_next   = pos_next[4:0];
  assign word_ext = {{PADW{1'b0}}, (pos_next[5] ? word_r : word_l)};

  always_ff @(posedge clk) begin
    if (!rst_n) sd <= 1'b0;
    else if (fall_tick) sd <= slot_bit(fmt, wl, k_next, word_ext);
  end

  // R2: data holds between falling bit-clock edges
  a_r2_sd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_tick |=> $stable(sd));

  // R5: left-justified slots past the word are zero
  a_r5_left_pad: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_tick && fmt == FMT_LEFT && k_next >= wl) |=> !sd);

  // R6: right-justified slots before the word are zero
  a_r6_right_pad: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_tick && fmt == FMT_RIGHT && {1'b0, k_next} < (6'd32 - {1'b0, wl})) |=> !sd);

endmodule

// File: rtl/i2s_quad_tx.sv
module i2s_quad_tx
  import i2s_ser_pkg::*;
#(
  parameter int LANES = 4,
  parameter int SW    = 24,
  parameter int DIVW  = 8
) (
  input  logic                    clk_m,
  input  logic                    rst_n,
  input  logic [DIVW-1:0]         cfg_div,
  input  logic [1:0]              cfg_mode,
  input  logic [4:0]              cfg_wl,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [LANES*2*SW-1:0]   in_samples,
  output logic                    sclk,
  output logic                    lrclk,
  output logic [LANES-1:0]        sd,
  output logic                    underrun
);

  localparam int SETW = LANES * 2 * SW;

  logic            fall_tick;
  logic            frame_start;
  logic [5:0]      pos_next;
  logic [SETW-1:0] pend;
  logic            pend_full;
  logic [SETW-1:0] act;
  fmt_e            fmt_q;
  logic [4:0]      wl_q;
  logic            accept;
  logic [SETW-1:0] set_sel;
  fmt_e            fmt_sel;
  logic [4:0]      wl_sel;

  assign in_ready = !pend_full;
  assign accept   = in_valid && !pend_full;

  // Values that apply to the slot being launched now.
  assign set_sel = (frame_start && pend_full) ? pend : act;
  assign fmt_sel = frame_start ? decode_fmt(cfg_mode) : fmt_q;
  assign wl_sel  = frame_start ? clamp_wl(cfg_wl, SW) : wl_q;

  i2s_clkdiv #(.DIVW(DIVW)) u_div (
    .clk       (clk_m),
    .rst_n     (rst_n),
    .half_m1   (cfg_div),
    .sclk      (sclk),
    .fall_tick (fall_tick)
  );

  i2s_framer u_frm (
    .clk         (clk_m),
    .rst_n       (rst_n),
    .fall_tick   (fall_tick),
    .pos_next    (pos_next),
    .frame_start (frame_start),
    .lrclk       (lrclk)
  );

  always_ff @(posedge clk_m) begin
    if (!rst_n) begin
      pend      <= '0;
      pend_full <= 1'b0;
      act       <= '0;
      fmt_q     <= FMT_I2S;
      wl_q      <= 5'd1;
      underrun  <= 1'b0;
    end else begin
      if (accept) begin
        pend      <= in_samples;
        pend_full <= 1'b1;
      end
      if (frame_start) begin
        fmt_q    <= fmt_sel;
        wl_q     <= wl_sel;
        underrun <= !pend_full;
        if (pend_full) begin
          act       <= pend;
          pend_full <= 1'b0;
        end
      end
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    i2s_lane #(.SW(SW)) u_lane (
      .clk       (clk_m),
      .rst_n     (rst_n),
      .fall_tick (fall_tick),
      .fmt       (fmt_sel),
      .wl        (wl_sel),
      .pos_next  (pos_next),
      .word_l    (set_sel[(2*l)*SW +: SW]),
      .word_r    (set_sel[(2*l+1)*SW +: SW]),
      .sd        (sd[l])
    );
  end

  // R9: an accepted set closes the buffer
  a_r9_ready_drop: assert property (@(posedge clk_m) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R9: the buffer only reopens at a frame start
  a_r9_reopen_at_frame: assert property (@(posedge clk_m) disable iff (!rst_n)
    $rose(in_ready) |-> $past(frame_start));

  // R10: the underrun flag only moves on a frame boundary
  a_r10_flag_at_frame: assert property (@(posedge clk_m) disable iff (!rst_n)
    $changed(underrun) |-> $past(frame_start));

  // R10: a frame started with an empty buffer is flagged
  a_r10_empty_flags: assert property (@(posedge clk_m) disable iff (!rst_n)
    (frame_start && !pend_full) |=> underrun);

endmodule

// File: tb/test_i2s_quad_tx.sv
`timescale 1ns/1ps
module test_i2s_quad_tx;

  localparam int LANES = 4;
  localparam int SW    = 24;

  logic                  clk_m = 1'b0;
  logic                  rst_n = 1'b0;
  logic [7:0]            cfg_div = '0;
  logic [1:0]            cfg_mode = '0;
  logic [4:0]            cfg_wl = 5'd24;
  logic                  in_valid = 1'b0;
  logic                  in_ready;
  logic [LANES*2*SW-1:0] in_samples = '0;
  logic                  sclk, lrclk, underrun;
  logic [LANES-1:0]      sd;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [31:0] cap [0:7][0:LANES-1][0:1];
  logic        urs [0:7];
  int          fidx;
  logic        cur_lr;
  int          edge_viol, duty_viol;

  always #2.5 clk_m = ~clk_m;

  i2s_quad_tx i_i2s_quad_tx (
    .clk_m(clk_m), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_mode(cfg_mode),
    .cfg_wl(cfg_wl), .in_valid(in_valid), .in_ready(in_ready),
    .in_samples(in_samples), .sclk(sclk), .lrclk(lrclk), .sd(sd),
    .underrun(underrun)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  // Test sample for frame n, lane l, channel c; the upper bits are kept busy.
  function automatic logic [23:0] gen(input int n, input int l, input int c);
    logic [31:0] v;
    v = 32'(n) * 32'h9E3779B1 + 32'(l) * 32'h0005A5A5 + 32'(c) * 32'h00C3C3C3 + 32'h00F0F00F;
    return v[31:8] ^ {v[7:0], v[23:8]};
  endfunction

  // Expected 32-slot image, slot 0 in bit 31.
  function automatic logic [31:0] slot_img(input int mode, input int wlraw, input logic [23:0] s);
    int w;
    logic [63:0] m;
    w = (wlraw < 1) ? 1 : (wlraw > 24 ? 24 : wlraw);
    m = 64'(s) & ((64'd1 << w) - 64'd1);
    if (mode == 1)      return 32'(m << (32 - w));
    else if (mode == 2) return 32'(m);
    else                return 32'(m << (31 - w));
  endfunction

  task automatic push(input int n);
    while (!in_ready) @(negedge clk_m);
    for (int l = 0; l < LANES; l++)
      for (int c = 0; c < 2; c++)
        in_samples[(2*l+c)*SW +: SW] = gen(n, l, c);
    in_valid = 1'b1;
    @(negedge clk_m);
    in_valid = 1'b0;
  endtask

  task automatic monitor(input int nchk, input int div);
    logic ps, plr, lastlr;
    logic [LANES-1:0] psd;
    int k, run;
    bit first_run;
    ps = sclk; plr = lrclk; psd = sd; lastlr = 1'b1;
    k = 0; run = 0; first_run = 1'b1;
    while (fidx < nchk) begin
      @(negedge clk_m);
      if ((sd != psd || lrclk != plr) && !(ps && !sclk)) edge_viol++;
      if (sclk != ps) begin
        if (!first_run && run != div + 1) duty_viol++;
        first_run = 1'b0;
        run = 1;
      end else run++;
      if (!ps && sclk) begin
        if (lrclk != lastlr) begin
          k = 0;
          if (!lrclk) fidx++;
        end else k++;
        lastlr = lrclk;
        cur_lr = lrclk;
        if (fidx >= 0 && fidx < 8 && k < 32) begin
          for (int l = 0; l < LANES; l++) cap[fidx][l][lrclk][31-k] = sd[l];
          if (k == 2 && !lrclk) urs[fidx] = underrun;
        end
      end
      ps = sclk; plr = lrclk; psd = sd;
    end
  endtask

  task automatic run_case(input int mode_a, input int mode_b, input int wl,
                          input int div, input bit gap, input bit chk_reset);
    int nchk, nfeed, src;
    nchk  = gap ? 5 : 3;
    nfeed = gap ? 2 : 4;
    rst_n = 1'b0; in_valid = 1'b0;
    cfg_mode = 2'(mode_a); cfg_wl = 5'(wl); cfg_div = 8'(div);
    repeat (3) @(negedge clk_m);
    if (chk_reset) begin
      check(sclk == 1'b0, "R12", "reset sclk", 32'(sclk), 0);
      check(lrclk == 1'b1, "R12", "reset lrclk", 32'(lrclk), 1);
      check(sd == '0, "R12", "reset sd", 32'(sd), 0);
      check(underrun == 1'b0, "R12", "reset underrun", 32'(underrun), 0);
      check(in_ready == 1'b1, "R12", "reset in_ready", 32'(in_ready), 1);
    end
    for (int f = 0; f < 8; f++) begin
      urs[f] = 1'bx;
      for (int l = 0; l < LANES; l++) begin cap[f][l][0] = 'x; cap[f][l][1] = 'x; end
    end
    fidx = -1; cur_lr = 1'b1; edge_viol = 0; duty_viol = 0;
    rst_n = 1'b1;
    fork
      begin
        for (int n = 0; n < nfeed; n++) push(n);
        if (gap) begin
          wait (fidx == 3);
          push(nfeed);
        end
      end
      monitor(nchk, div);
      begin
        if (mode_b != mode_a) begin
          wait (fidx == 0 && cur_lr == 1'b1);
          @(negedge clk_m);
          cfg_mode = 2'(mode_b);  // R11: mid-frame change
        end
      end
    join
    for (int f = 0; f < nchk; f++) begin
      src = gap ? (f < 2 ? f : (f < 4 ? 1 : 2)) : f;
      for (int l = 0; l < LANES; l++)
        for (int c = 0; c < 2; c++)
          // R3 R4 R5 R6 R7 R8 R11: slot image per lane and channel
          check(cap[f][l][c] === slot_img(f == 0 ? mode_a : mode_b, wl, gen(src, l, c)),
                "R3-R8/R11", $sformatf("frame %0d lane %0d ch %0d mode %0d", f, l, c,
                f == 0 ? mode_a : mode_b), cap[f][l][c],
                slot_img(f == 0 ? mode_a : mode_b, wl, gen(src, l, c)));
      // R10: flag per frame
      check(urs[f] === ((gap && (f == 2 || f == 3)) ? 1'b1 : 1'b0), "R10",
            $sformatf("underrun frame %0d", f), 32'(urs[f]),
            32'((gap && (f == 2 || f == 3)) ? 1 : 0));
    end
    check(edge_viol == 0, "R2", "changes away from falling sclk", 32'(edge_viol), 0);
    check(duty_viol == 0, "R1", "sclk phase length", 32'(duty_viol), 0);
    check(in_ready == (gap ? 1'b1 : 1'b0) || !gap, "R9", "buffer state after run",
          32'(in_ready), 32'(gap ? 1 : 0));
  endtask

  initial begin
    run_case(0, 0, 24, 0, 1'b0, 1'b1);  // R4 standard, full width
    run_case(1, 1, 16, 0, 1'b0, 1'b0);  // R5 left-justified
    run_case(2, 2, 8,  1, 1'b0, 1'b0);  // R6 right-justified, divide by 4
    run_case(1, 1, 0,  0, 1'b0, 1'b0);  // R7 clamp up to 1
    run_case(2, 2, 31, 2, 1'b0, 1'b0);  // R7 clamp down to 24
    run_case(0, 0, 1,  0, 1'b0, 1'b0);  // R4 one-bit word
    run_case(3, 3, 20, 1, 1'b0, 1'b0);  // R4 code 3 behaves as standard
    run_case(1, 2, 12, 0, 1'b0, 1'b0);  // R11 mode switch mid-frame
    run_case(0, 0, 24, 0, 1'b1, 1'b0);  // R9 R10 input gap
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_m);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule